// File: doc/BRIEF.md
# Sleep Mode Clock Controller

This block decides which clock domains and which oscillators of a small processor system run at any moment. Software programs a 3-bit sleep mode, a sleep-enable bit and a mask with one clock-stop bit per peripheral. A one-cycle sleep strobe, issued when the processor executes its sleep instruction, moves the controller from the active state into the programmed sleep mode. Each mode has its own set of wake inputs, and any one of them returns the controller to active.

The outputs are clock enables for the CPU, the memories, DMA, the event routing fabric, the interrupt controller and each peripheral. There are also run-enables for the main oscillator, the crystal oscillator and the real-time-counter oscillator. A status output reports the current state. Glitch-free clock gating cells and the oscillators themselves sit outside this block.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After reset the state is active (status code 001), sleep-enable and the peripheral clock-stop mask are cleared, and every clock and oscillator enable is 1.
- R2: In the active state cpu, memory, DMA, event and interrupt-controller enables and all three oscillator enables are 1. Peripheral enable bit i is the inverse of mask bit i. A mask write takes effect on the outputs in the cycle after the write edge.
- R3: A sleep strobe in the active state, with sleep-enable set and a valid mode code, moves the state at that clock edge to the mode code. Valid codes are 000 Idle, 010 Power-down, 011 Power-save, 110 Standby and 111 Extended Standby, and the status output shows the code. The strobe uses the configuration held before that edge.
- R4: A sleep strobe with sleep-enable clear is ignored, and the state stays active.
- R5: A sleep strobe carrying a reserved mode code (001, 100, 101) is ignored, and the state stays active.
- R6: In Idle only the CPU enable is 0. The other domains and all oscillators stay on, and the peripheral enables still follow the inverted mask.
- R7: In Power-down every clock and oscillator enable is 0. Only the two-wire address-match wake and the pin-change wake end it.
- R8: Power-save matches Power-down except that the RTC oscillator enable is 1, and the RTC wake also ends it.
- R9: In Standby only the crystal oscillator enable is 1. Only the two-wire and pin-change wakes end it.
- R10: In Extended Standby only the main and RTC oscillator enables are 1. The two-wire, pin-change and RTC wakes end it.
- R11: Idle is ended by the interrupt request input or by any of the three wake inputs.
- R12: An accepted wake returns the state to active at the next clock edge, and all enables take their active values with the mask applied. Wake inputs that the current mode does not accept, and sleep strobes issued while asleep, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for mode and sleep-enable |
| cfg_mode | input | 3 | Sleep mode code to store |
| cfg_sleep_en | input | 1 | Sleep-enable value to store |
| mask_we | input | 1 | Write strobe for the peripheral clock-stop mask |
| mask_in | input | NPERIPH | Clock-stop mask value, 1 stops that peripheral |
| sleep_req | input | 1 | Sleep instruction strobe |
| irq_any | input | 1 | Any enabled interrupt request pending |
| wake_twi | input | 1 | Two-wire address-match wake |
| wake_pin | input | 1 | Pin-change wake |
| wake_rtc | input | 1 | Real-time-counter wake |
| cpu_clk_en | output | 1 | CPU clock enable |
| mem_clk_en | output | 1 | Memory clock enable |
| dma_clk_en | output | 1 | DMA clock enable |
| evt_clk_en | output | 1 | Event routing clock enable |
| intc_clk_en | output | 1 | Interrupt controller clock enable |
| periph_clk_en | output | NPERIPH | Per-peripheral clock enables |
| osc_main_en | output | 1 | Main oscillator run-enable |
| osc_xtal_en | output | 1 | Crystal oscillator run-enable |
| osc_rtc_en | output | 1 | RTC oscillator run-enable |
| state_o | output | 3 | Current state: 001 active, otherwise the mode code |

## Verification
The hardest case to reach is a wake input that the current mode must refuse, for example an RTC wake during Power-down or an interrupt during Standby. A refused wake leaves no trace unless the bench holds the controller asleep and looks right away. The bench therefore sweeps all eight mode codes against both sleep-enable values and several masks. In each sleep mode it reached, it applies all sixteen combinations of the four wake inputs one cycle at a time, and it puts the controller back to sleep after every accepted wake. The state and all enables are compared after each step with values worked out from the mode table.

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl #(
  parameter int NPERIPH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_mode,
  input  logic               cfg_sleep_en,
  input  logic               mask_we,
  input  logic [NPERIPH-1:0] mask_in,
  input  logic               sleep_req,
  input  logic               irq_any,
  input  logic               wake_twi,
  input  logic               wake_pin,
  input  logic               wake_rtc,
  output logic               cpu_clk_en,
  output logic               mem_clk_en,
  output logic               dma_clk_en,
  output logic               evt_clk_en,
  output logic               intc_clk_en,
  output logic [NPERIPH-1:0] periph_clk_en,
  output logic               osc_main_en,
  output logic               osc_xtal_en,
  output logic               osc_rtc_en,
  output logic [2:0]         state_o
);

  localparam logic [2:0] ST_ACT  = 3'b001;
  localparam logic [2:0] M_IDLE  = 3'b000;
  localparam logic [2:0] M_PDOWN = 3'b010;
  localparam logic [2:0] M_PSAVE = 3'b011;
  localparam logic [2:0] M_STBY  = 3'b110;
  localparam logic [2:0] M_XSTBY = 3'b111;

  logic [2:0]         state;
  logic [2:0]         mode_r;
  logic               slp_en_r;
  logic [NPERIPH-1:0] mask_r;
  logic               mode_ok;
  logic               go_sleep;
  logic               wake_hit;
  logic               is_act, is_idle, bus_on;

  assign mode_ok = (mode_r == M_IDLE) || (mode_r == M_PDOWN) || (mode_r == M_PSAVE) ||
                   (mode_r == M_STBY) || (mode_r == M_XSTBY);
  assign go_sleep = is_act && sleep_req && slp_en_r && mode_ok;

  always_comb begin
    case (state)
      M_IDLE:          wake_hit = irq_any | wake_twi | wake_pin | wake_rtc;
      M_PDOWN, M_STBY: wake_hit = wake_twi | wake_pin;
      M_PSAVE,
      M_XSTBY:         wake_hit = wake_twi | wake_pin | wake_rtc;
      default:         wake_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r   <= M_IDLE;
      slp_en_r <= 1'b0;
      mask_r   <= '0;
    end else begin
      if (cfg_we) begin
        mode_r   <= cfg_mode;
        slp_en_r <= cfg_sleep_en;
      end
      if (mask_we) mask_r <= mask_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= ST_ACT;
    else if (go_sleep) state <= mode_r;
    else if (wake_hit) state <= ST_ACT;
  end

  assign is_act  = (state == ST_ACT);
  assign is_idle = (state == M_IDLE);
  assign bus_on  = is_act || is_idle;

  assign cpu_clk_en    = is_act;
  assign mem_clk_en    = bus_on;
  assign dma_clk_en    = bus_on;
  assign evt_clk_en    = bus_on;
  assign intc_clk_en   = bus_on;
  assign periph_clk_en = bus_on ? ~mask_r : '0;
  assign osc_main_en   = bus_on || (state == M_XSTBY);
  assign osc_xtal_en   = bus_on || (state == M_STBY);
  assign osc_rtc_en    = bus_on || (state == M_PSAVE) || (state == M_XSTBY);
  assign state_o       = state;

  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_sleep |=> (state_o == $past(mode_r)));

  // R4
  sleep_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && sleep_req && !slp_en_r) |=> (state_o == ST_ACT));

  // R5
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && sleep_req && !mode_ok) |=> cpu_clk_en);

  // R7
  pdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == M_PDOWN) && !wake_twi && !wake_pin) |=> (state_o == M_PDOWN));

  // R12
  wake_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_act && wake_hit) |=> (cpu_clk_en && osc_main_en && mem_clk_en));

  // R2
  sleep_no_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (osc_main_en && osc_xtal_en && osc_rtc_en && intc_clk_en));

endmodule

// File: tb/sleep_clk_ctrl_bench.sv
module sleep_clk_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_sleep_en = 0, mask_we = 0, sleep_req = 0;
  logic [2:0] cfg_mode = 0;
  logic [NP-1:0] mask_in = 0;
  logic irq_any = 0, wake_twi = 0, wake_pin = 0, wake_rtc = 0;
  logic cpu_clk_en, mem_clk_en, dma_clk_en, evt_clk_en, intc_clk_en;
  logic [NP-1:0] periph_clk_en;
  logic osc_main_en, osc_xtal_en, osc_rtc_en;
  logic [2:0] state_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_clk_ctrl #(.NPERIPH(NP)) u_sleep_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_sleep_en(cfg_sleep_en), .mask_we(mask_we), .mask_in(mask_in),
    .sleep_req(sleep_req), .irq_any(irq_any), .wake_twi(wake_twi),
    .wake_pin(wake_pin), .wake_rtc(wake_rtc), .cpu_clk_en(cpu_clk_en),
    .mem_clk_en(mem_clk_en), .dma_clk_en(dma_clk_en), .evt_clk_en(evt_clk_en),
    .intc_clk_en(intc_clk_en), .periph_clk_en(periph_clk_en),
    .osc_main_en(osc_main_en), .osc_xtal_en(osc_xtal_en),
    .osc_rtc_en(osc_rtc_en), .state_o(state_o)
  );

  function automatic logic valid_code(input logic [2:0] c);
    return c == 3'b000 || c == 3'b010 || c == 3'b011 || c == 3'b110 || c == 3'b111;
  endfunction

  // {cpu,mem,dma,evt,intc,main,xtal,rtc,periph}
  function automatic logic [8+NP-1:0] exp_outs(input logic [2:0] st, input logic [NP-1:0] m);
    logic [7:0] b;
    logic [NP-1:0] p;
    p = '0;
    case (st)
      3'b001:  begin b = 8'b11111_111; p = ~m; end
      3'b000:  begin b = 8'b01111_111; p = ~m; end
      3'b010:  b = 8'b00000_000;
      3'b011:  b = 8'b00000_001;
      3'b110:  b = 8'b00000_010;
      3'b111:  b = 8'b00000_101;
      default: b = 8'hxx;
    endcase
    return {b, p};
  endfunction

  // wake bits {irq,twi,pin,rtc}
  function automatic logic accepts(input logic [2:0] st, input logic [3:0] w);
    case (st)
      3'b000:         return |w;
      3'b010, 3'b110: return w[2] | w[1];
      3'b011, 3'b111: return w[2] | w[1] | w[0];
      default:        return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] st, input logic [NP-1:0] m);
    logic [8+NP-1:0] act, exp;
    act = {cpu_clk_en, mem_clk_en, dma_clk_en, evt_clk_en, intc_clk_en,
           osc_main_en, osc_xtal_en, osc_rtc_en, periph_clk_en};
    exp = exp_outs(st, m);
    checks++;
    if (state_o !== st || act !== exp) begin
      errors++;
      $display("FAIL %s state=%b outs=%b expected state=%b outs=%b", req, state_o, act, st, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic sleep_pulse;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
  endtask

  initial begin
    logic [2:0] cur;
    logic [NP-1:0] msk;
    step();
    check("R1", 3'b001, '0);
    rst_n = 1'b1;
    step();
    check("R1", 3'b001, '0);
    // R4: sleep-enable clear after reset
    sleep_pulse();
    check("R4", 3'b001, '0);

    for (int m = 0; m < 8; m++) begin
      for (int e = 0; e < 2; e++) begin
        msk = NP'((m * 5 + e * 3 + 1) % 16);
        cfg_we = 1; cfg_mode = 3'(m); cfg_sleep_en = e[0];
        mask_we = 1; mask_in = msk;
        step();
        cfg_we = 0; mask_we = 0;
        check("R2", 3'b001, msk);
        // R3: strobe in the same cycle as a config write uses old values
        cfg_we = 1; cfg_mode = 3'b001; cfg_sleep_en = 1'b0;
        sleep_req = 1'b1;
        step();
        cfg_we = 0; sleep_req = 0;
        cur = (e == 1 && valid_code(3'(m))) ? 3'(m) : 3'b001;
        check(e == 0 ? "R4" : (valid_code(3'(m)) ? "R3" : "R5"), cur, msk);
        if (cur != 3'b001) begin
          check(m == 0 ? "R6" : m == 2 ? "R7" : m == 3 ? "R8" : m == 6 ? "R9" : "R10", cur, msk);
          // R12: sleep strobe while asleep has no effect
          sleep_pulse();
          check("R12", cur, msk);
          for (int w = 0; w < 16; w++) begin
            {irq_any, wake_twi, wake_pin, wake_rtc} = 4'(w);
            step();
            {irq_any, wake_twi, wake_pin, wake_rtc} = 4'b0000;
            if (accepts(cur, 4'(w))) begin
              check(m == 0 ? "R11" : "R12", 3'b001, msk);
              cfg_we = 1; cfg_mode = 3'(m); cfg_sleep_en = 1'b1;
              step();
              cfg_we = 0;
              sleep_pulse();
              check("R3", cur, msk);
            end else begin
              check(m == 2 ? "R7" : m == 3 ? "R8" : m == 6 ? "R9" : "R10", cur, msk);
            end
          end
          wake_pin = 1;
          step();
          wake_pin = 0;
          check("R12", 3'b001, msk);
        end
        // R2: wakes in active change nothing
        {irq_any, wake_twi, wake_pin, wake_rtc} = 4'b1111;
        step();
        {irq_any, wake_twi, wake_pin, wake_rtc} = 4'b0000;
        check("R2", 3'b001, msk);
      end
    end

    // R1: reset mid-sleep clears mask and sleep-enable
    cfg_we = 1; cfg_mode = 3'b010; cfg_sleep_en = 1;
    mask_we = 1; mask_in = 4'b1010;
    step();
    cfg_we = 0; mask_we = 0;
    sleep_pulse();
    check("R7", 3'b010, 4'b1010);
    rst_n = 0;
    step();
    check("R1", 3'b001, '0);
    rst_n = 1;
    step();
    sleep_pulse();
    check("R1", 3'b001, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule